// File: doc/BRIEF.md
# Interrupt CPU Target Register Bank

This block keeps, for every interrupt line, an 8-bit mask that names the CPUs a shared interrupt may be routed to. Software reaches the masks through a byte-addressed register window. The field for line n lives at byte offset n of the window. An access is either a single byte or an aligned 32-bit word, and a word carries four neighbouring lines.

The lowest 32 lines are private to each CPU. Their fields cannot be written, and when read they show the accessing CPU's own bit. When software writes a shared-line field, the block first trims the value to the CPUs that are currently online, then stores it. From each stored mask the block continuously derives one destination CPU index, which the interrupt delivery logic uses. That delivery logic lies outside this block.

Read data comes back one clock after the request, from a register. The store and the destination outputs change at the clock edge that accepts a write.

Top module: `tgt_route_bank`

## Requirements
- R1: The field of line n is at byte offset n. A byte read returns that field in rd_data[7:0], and rd_data[31:8] are zero.
- R2: A word access ignores acc_addr[1:0] and covers the four lines starting at the aligned offset. The lowest line is in rd_data[7:0] (or acc_wdata[7:0]), and the highest line is in bits [31:24].
- R3: A write is dropped entirely when its first line number (the aligned offset for a word) is below 32. No stored mask changes.
- R4: Each written byte is ANDed with (1 << cpus_online) - 1 before it is stored. The cpus_online value used is the one presented in the same cycle as the write.
- R5: For each shared line, dest_cpu gives the index of the lowest set bit of the stored mask, or 0 when the mask is zero. Shared line s occupies dest_cpu[(s-32)*3 +: 3]. The output reflects a write from the clock edge that accepts it.
- R6: rd_valid is high exactly in the cycle after an accepted read request, with rd_data registered at that edge. rd_valid is low after writes and idle cycles.
- R7: A read of a private line returns 1 << acc_cpu in that line's byte lane.
- R8: After reset, every shared mask reads zero, every dest_cpu field is 0 and rd_valid is low.
- R9: Lines at or above NUM_LINES read as zero. Writes to them change no stored mask and no dest_cpu field.
- R10: A stored mask is not re-trimmed when cpus_online later drops. It reads back and routes as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| acc_addr | input | WIN_AW | Byte offset in the window |
| acc_wdata | input | 32 | Write data (byte access uses bits [7:0]) |
| acc_cpu | input | 3 | Index of the accessing CPU |
| cpus_online | input | 4 | Number of online CPUs, 0 to 8 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, packed by byte lane |
| dest_cpu | output | (NUM_LINES-32)*3 | Chosen CPU index per shared line |

## Verification
The trimming to online CPUs and the write share one cycle: cpus_online is changed on the same cycle as a write request. The stored mask must match the count presented with that write, not the count before or after it. The bench provokes this with writes whose online count differs from the neighbouring cycles. It judges the result both by reading the field back and by checking the destination index, which must follow the trimmed mask. The bench also drops the online count below a stored mask's highest bit to show that the stored value is left alone afterwards.

// File: rtl/tgt_route_pkg.sv
package tgt_route_pkg;
  localparam int FIELD_W  = 8;
  localparam int CPU_IDW  = 3;
  localparam int CNT_W    = 4;
  localparam int LANES    = 4;

  function automatic logic [FIELD_W-1:0] online_mask(input logic [CNT_W-1:0] cnt);
    logic [FIELD_W-1:0] m;
    for (int i = 0; i < FIELD_W; i++) begin
      m[i] = (CNT_W'(i) < cnt);
    end
    return m;
  endfunction

  function automatic logic [CPU_IDW-1:0] lowest_idx(input logic [FIELD_W-1:0] m);
    logic [CPU_IDW-1:0] r;
    r = '0;
    for (int i = FIELD_W - 1; i >= 0; i--) begin
      if (m[i]) r = CPU_IDW'(i);
    end
    return r;
  endfunction

  function automatic logic [FIELD_W-1:0] own_bit(input logic [CPU_IDW-1:0] cpu);
    return FIELD_W'(1) << cpu;
  endfunction
endpackage

// File: rtl/tgt_acc_decode.sv
module tgt_acc_decode
  import tgt_route_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIV_LINES = 32,
  parameter int WIN_AW     = 10,
  localparam int LW        = WIN_AW + 1
) (
  input  logic                           acc_valid,
  input  logic                           acc_write,
  input  logic                           acc_word,
  input  logic [WIN_AW-1:0]              acc_addr,
  input  logic [31:0]                    acc_wdata,
  output logic [LW-1:0]                  first_line,
  output logic [LANES-1:0][LW-1:0]       lane_line,
  output logic [LANES-1:0]               lane_act,
  output logic [LANES-1:0]               lane_in_range,
  output logic [LANES-1:0]               lane_private,
  output logic [LANES-1:0]               lane_we,
  output logic [LANES-1:0][FIELD_W-1:0]  lane_wbyte,
  output logic                           wr_dropped
);
  logic wr_req;
  logic first_private;

  always_comb begin
    if (acc_word) first_line = {1'b0, acc_addr[WIN_AW-1:2], 2'b00};
    else          first_line = {1'b0, acc_addr};
  end

  assign wr_req        = acc_valid & acc_write;
  assign first_private = (first_line < LW'(PRIV_LINES));
  assign wr_dropped    = wr_req & first_private;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_line[k]     = first_line + LW'(k);
    assign lane_act[k]      = (k == 0) ? 1'b1 : acc_word;
    assign lane_in_range[k] = (lane_line[k] < LW'(NUM_LINES));
    assign lane_private[k]  = (lane_line[k] < LW'(PRIV_LINES));
    assign lane_wbyte[k]    = acc_wdata[k*FIELD_W +: FIELD_W];
    assign lane_we[k]       = wr_req & lane_act[k] & lane_in_range[k] & ~first_private;
  end
endmodule

// File: rtl/tgt_mask_store.sv
module tgt_mask_store
  import tgt_route_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIV_LINES = 32,
  parameter int LW         = 11,
  localparam int NSH       = NUM_LINES - PRIV_LINES
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               lane_we,
  input  logic [LANES-1:0][LW-1:0]       lane_line,
  input  logic [LANES-1:0][FIELD_W-1:0]  lane_wbyte,
  input  logic [FIELD_W-1:0]             clip,
  output logic [NSH*FIELD_W-1:0]         mask_flat
);
  for (genvar s = 0; s < NSH; s++) begin : g_line
    logic               hit;
    logic [FIELD_W-1:0] nxt;
    logic [FIELD_W-1:0] q;

    always_comb begin
      hit = 1'b0;
      nxt = '0;
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k] && lane_line[k] == LW'(s + PRIV_LINES)) begin
          hit = 1'b1;
          nxt = lane_wbyte[k] & clip;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= nxt;
    end

    assign mask_flat[s*FIELD_W +: FIELD_W] = q;
  end
endmodule

// File: rtl/tgt_dest_pick.sv
module tgt_dest_pick
  import tgt_route_pkg::*;
#(
  parameter int NSH = 32
) (
  input  logic [NSH*FIELD_W-1:0] mask_flat,
  output logic [NSH*CPU_IDW-1:0] dest_flat
);
  for (genvar s = 0; s < NSH; s++) begin : g_pick
    assign dest_flat[s*CPU_IDW +: CPU_IDW] = lowest_idx(mask_flat[s*FIELD_W +: FIELD_W]);
  end
endmodule

// File: rtl/tgt_read_pack.sv
module tgt_read_pack
  import tgt_route_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIV_LINES = 32,
  parameter int LW         = 11,
  localparam int NSH       = NUM_LINES - PRIV_LINES
) (
  input  logic [LANES-1:0][LW-1:0]  lane_line,
  input  logic [LANES-1:0]          lane_act,
  input  logic [LANES-1:0]          lane_in_range,
  input  logic [LANES-1:0]          lane_private,
  input  logic [NSH*FIELD_W-1:0]    mask_flat,
  input  logic [CPU_IDW-1:0]        acc_cpu,
  output logic [31:0]               rdata
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [FIELD_W-1:0] b;
    always_comb begin
      b = '0;
      if (lane_act[k]) begin
        if (lane_private[k]) begin
          b = own_bit(acc_cpu);
        end else if (lane_in_range[k]) begin
          for (int s = 0; s < NSH; s++) begin
            if (lane_line[k] == LW'(s + PRIV_LINES)) b = mask_flat[s*FIELD_W +: FIELD_W];
          end
        end
      end
    end
    assign rdata[k*FIELD_W +: FIELD_W] = b;
  end
endmodule

// File: rtl/tgt_route_bank.sv
module tgt_route_bank
  import tgt_route_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIV_LINES = 32,
  parameter int WIN_AW     = 10,
  localparam int LW        = WIN_AW + 1,
  localparam int NSH       = NUM_LINES - PRIV_LINES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic                      acc_word,
  input  logic [WIN_AW-1:0]         acc_addr,
  input  logic [31:0]               acc_wdata,
  input  logic [CPU_IDW-1:0]        acc_cpu,
  input  logic [CNT_W-1:0]          cpus_online,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  output logic [NSH*CPU_IDW-1:0]    dest_cpu
);
  logic [LW-1:0]                  first_line;
  logic [LANES-1:0][LW-1:0]       lane_line;
  logic [LANES-1:0]               lane_act;
  logic [LANES-1:0]               lane_in_range;
  logic [LANES-1:0]               lane_private;
  logic [LANES-1:0]               lane_we;
  logic [LANES-1:0][FIELD_W-1:0]  lane_wbyte;
  logic                           wr_dropped;
  logic [FIELD_W-1:0]             clip;
  logic [NSH*FIELD_W-1:0]         mask_flat;
  logic [31:0]                    rdata_nxt;
  logic                           rd_req;

  tgt_acc_decode #(.NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .WIN_AW(WIN_AW)) u_dec (
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_word(acc_word),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .first_line(first_line),
    .lane_line(lane_line), .lane_act(lane_act), .lane_in_range(lane_in_range),
    .lane_private(lane_private), .lane_we(lane_we), .lane_wbyte(lane_wbyte),
    .wr_dropped(wr_dropped)
  );

  assign clip = online_mask(cpus_online);

  tgt_mask_store #(.NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .lane_line(lane_line),
    .lane_wbyte(lane_wbyte), .clip(clip), .mask_flat(mask_flat)
  );

  tgt_dest_pick #(.NSH(NSH)) u_pick (
    .mask_flat(mask_flat), .dest_flat(dest_cpu)
  );

  tgt_read_pack #(.NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .LW(LW)) u_rd (
    .lane_line(lane_line), .lane_act(lane_act), .lane_in_range(lane_in_range),
    .lane_private(lane_private), .mask_flat(mask_flat), .acc_cpu(acc_cpu),
    .rdata(rdata_nxt)
  );

  assign rd_req = acc_valid & ~acc_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rdata_nxt;
    end
  end
endmodule

// File: rtl/tgt_route_bank_chk.sv
module tgt_route_bank_chk
  import tgt_route_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int PRIV_LINES = 32,
  parameter int WIN_AW     = 10,
  localparam int LW        = WIN_AW + 1,
  localparam int NSH       = NUM_LINES - PRIV_LINES
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      acc_valid,
  input logic                      acc_write,
  input logic                      acc_word,
  input logic [WIN_AW-1:0]         acc_addr,
  input logic [CPU_IDW-1:0]        acc_cpu,
  input logic [CNT_W-1:0]          cpus_online,
  input logic                      rd_valid,
  input logic [31:0]               rd_data,
  input logic [NSH*FIELD_W-1:0]    mask_flat,
  input logic [NSH*CPU_IDW-1:0]    dest_cpu,
  input logic [LW-1:0]             first_line,
  input logic [LANES-1:0]          lane_we,
  input logic [LANES-1:0][LW-1:0]  lane_line
);
  function automatic logic [FIELD_W-1:0] field_of(input logic [NSH*FIELD_W-1:0] f,
                                                  input logic [LW-1:0] line);
    logic [FIELD_W-1:0] r;
    r = '0;
    for (int s = 0; s < NSH; s++) begin
      if (line == LW'(s + PRIV_LINES)) r = f[s*FIELD_W +: FIELD_W];
    end
    return r;
  endfunction

  // R3: a write starting on a private line leaves every shared mask unchanged
  a_r3_private_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && first_line < LW'(PRIV_LINES)) |=> $stable(mask_flat));

  // R4: the stored lane-0 byte fits the online set presented with the write
  a_r4_clip_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we[0] |=> ((field_of(mask_flat, $past(lane_line[0])) &
                     ~online_mask($past(cpus_online))) == '0));

  // R6: read response timing
  a_r6_rd_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  a_r6_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write) |=> !rd_valid);

  // R7: private byte read returns the accessing CPU's own bit
  a_r7_private_read: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !acc_word && acc_addr < WIN_AW'(PRIV_LINES))
      |=> (rd_data == {24'h0, own_bit($past(acc_cpu))}));

  // R5: every destination is the lowest set bit of its mask, or 0 if empty
  for (genvar s = 0; s < NSH; s++) begin : g_dst
    logic [FIELD_W-1:0] m;
    logic [CPU_IDW-1:0] d;
    assign m = mask_flat[s*FIELD_W +: FIELD_W];
    assign d = dest_cpu[s*CPU_IDW +: CPU_IDW];
    a_r5_lowest_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (m == '0) ? (d == '0)
                : (m[d] && ((m & ((FIELD_W'(1) << d) - FIELD_W'(1))) == '0)));
  end
endmodule

bind tgt_route_bank tgt_route_bank_chk #(
  .NUM_LINES(NUM_LINES), .PRIV_LINES(PRIV_LINES), .WIN_AW(WIN_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_word(acc_word), .acc_addr(acc_addr), .acc_cpu(acc_cpu),
  .cpus_online(cpus_online), .rd_valid(rd_valid), .rd_data(rd_data),
  .mask_flat(mask_flat), .dest_cpu(dest_cpu), .first_line(first_line),
  .lane_we(lane_we), .lane_line(lane_line)
);

// File: tb/tb_tgt_route_bank.sv
module tb_tgt_route_bank;
  localparam int NL   = 64;
  localparam int PRIV = 32;
  localparam int AW   = 10;
  localparam int NSH  = NL - PRIV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic              acc_write = 1'b0;
  logic              acc_word = 1'b0;
  logic [AW-1:0]     acc_addr = '0;
  logic [31:0]       acc_wdata = '0;
  logic [2:0]        acc_cpu = '0;
  logic [3:0]        cpus_online = 4'd8;
  logic              rd_valid;
  logic [31:0]       rd_data;
  logic [NSH*3-1:0]  dest_cpu;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NL];
  logic [31:0] got;

  always #10 clk = ~clk;

  tgt_route_bank #(.NUM_LINES(NL), .PRIV_LINES(PRIV), .WIN_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_cpu(acc_cpu), .cpus_online(cpus_online), .rd_valid(rd_valid),
    .rd_data(rd_data), .dest_cpu(dest_cpu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] trim(input int cnt);
    if (cnt >= 8) return 8'hFF;
    return (8'd1 << cnt) - 8'd1;
  endfunction

  function automatic logic [2:0] first_one(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return 3'(i);
    return 3'd0;
  endfunction

  // one write at a negedge, accepted on the next posedge; ends at a negedge
  task automatic wr(input bit word, input int addr, input logic [31:0] d, input int online);
    int base;
    acc_valid = 1'b1; acc_write = 1'b1; acc_word = word;
    acc_addr = AW'(addr); acc_wdata = d; cpus_online = 4'(online);
    base = word ? (addr & ~3) : addr;
    if (base >= PRIV)
      for (int k = 0; k < (word ? 4 : 1); k++)
        if (base + k < NL) model[base + k] = d[k*8 +: 8] & trim(online);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic rd(input bit word, input int addr, input int cpu, output logic [31:0] q);
    acc_valid = 1'b1; acc_write = 1'b0; acc_word = word;
    acc_addr = AW'(addr); acc_cpu = 3'(cpu);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R6 rd_valid after read", 32'(rd_valid), 32'd1);
    q = rd_data;
  endtask

  function automatic logic [31:0] exp_word(input int base, input int cpu);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int ln = base + k;
      if (ln < PRIV) r[k*8 +: 8] = 8'd1 << cpu;
      else if (ln < NL) r[k*8 +: 8] = model[ln];
    end
    return r;
  endfunction

  task automatic chk_all_dest(input string tag);
    for (int s = 0; s < NSH; s++)
      chk(tag, 32'(dest_cpu[s*3 +: 3]), 32'(first_one(model[s + PRIV])));
  endtask

  task automatic t_reset;
    chk("R8 rd_valid low after reset", 32'(rd_valid), 32'd0);
    chk_all_dest("R8 dest zero after reset");
    rd(1'b1, 32, 0, got);
    chk("R8 shared masks zero", got, 32'h0);
  endtask

  task automatic t_byte_map;
    wr(1'b0, 40, 32'h0000_000C, 8);
    chk("R6 rd_valid low after write", 32'(rd_valid), 32'd0);
    chk("R5 dest line40", 32'(dest_cpu[8*3 +: 3]), 32'd2);
    rd(1'b0, 40, 0, got);
    chk("R1 byte read line40", got, 32'h0000_000C);
    rd(1'b0, 41, 0, got);
    chk("R1 byte read line41", got, 32'h0);
  endtask

  task automatic t_word;
    wr(1'b1, 43, 32'h8001_0600, 8);
    rd(1'b1, 41, 0, got);
    chk("R2 word lanes line40..43", got, 32'h8001_0600);
    chk("R5 dest empty mask line40", 32'(dest_cpu[8*3 +: 3]), 32'd0);
    chk("R5 dest line41", 32'(dest_cpu[9*3 +: 3]), 32'd1);
    chk("R5 dest line43", 32'(dest_cpu[11*3 +: 3]), 32'd7);
    rd(1'b0, 43, 0, got);
    chk("R1 byte read line43", got, 32'h0000_0080);
  endtask

  task automatic t_private;
    wr(1'b1, 0, 32'hFFFF_FFFF, 8);
    wr(1'b0, 31, 32'hFF, 8);
    wr(1'b1, 28, 32'hFFFF_FFFF, 8);
    rd(1'b1, 0, 5, got);
    chk("R7 private word cpu5", got, 32'h2020_2020);
    rd(1'b0, 31, 2, got);
    chk("R7 private byte cpu2", got, 32'h0000_0004);
    rd(1'b1, 32, 0, got);
    chk("R3 shared untouched by private writes", got, exp_word(32, 0));
    chk_all_dest("R3 dest untouched");
  endtask

  task automatic t_clip;
    wr(1'b0, 50, 32'hFE, 3);
    rd(1'b0, 50, 0, got);
    chk("R4 clip to 3 online", got, 32'h06);
    chk("R5 dest clipped line50", 32'(dest_cpu[18*3 +: 3]), 32'd1);
    wr(1'b1, 44, 32'hFFFF_FFFF, 1);
    cpus_online = 4'd8;
    rd(1'b1, 44, 0, got);
    chk("R4 clip to 1 online word", got, 32'h0101_0101);
    wr(1'b0, 52, 32'hF0, 0);
    rd(1'b0, 52, 0, got);
    chk("R4 clip to 0 online", got, 32'h0);
  endtask

  task automatic t_noreclip;
    wr(1'b0, 51, 32'h80, 8);
    cpus_online = 4'd2;
    @(negedge clk);
    rd(1'b0, 51, 0, got);
    chk("R10 stored mask kept", got, 32'h80);
    chk("R10 dest kept", 32'(dest_cpu[19*3 +: 3]), 32'd7);
    cpus_online = 4'd8;
  endtask

  task automatic t_beyond;
    wr(1'b1, 64, 32'hFFFF_FFFF, 8);
    wr(1'b0, 100, 32'hFF, 8);
    rd(1'b1, 64, 0, got);
    chk("R9 word beyond reads zero", got, 32'h0);
    rd(1'b0, 100, 0, got);
    chk("R9 byte beyond reads zero", got, 32'h0);
    rd(1'b1, 60, 0, got);
    chk("R9 last shared word intact", got, exp_word(60, 0));
    chk_all_dest("R9 dest intact");
  endtask

  task automatic t_sweep;
    for (int b = 0; b < 8; b++) begin
      wr(1'b0, 33, 32'(8'h80 | (8'd1 << b)), 8);
      chk("R5 sweep dest line33", 32'(dest_cpu[1*3 +: 3]), 32'(b));
    end
    chk_all_dest("R5 full dest compare");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) model[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte_map;
    t_word;
    t_private;
    t_clip;
    t_noreclip;
    t_beyond;
    t_sweep;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule